// File: doc/BRIEF.md
# Speculative Store Group Tracker

This block keeps the bookkeeping for groups of memory accesses that a core retires speculatively, ahead of the ordering rules of its consistency model. A group opens whenever an ordering rule would otherwise hold retirement, for example a load reaching retirement while stores are still outstanding. While it accumulates, the group collects the indices of the stores it appends to the store log. It also counts the distinct cache lines it writes and the lines whose write permission has arrived. A closed group waits for its missing permissions. When it is the oldest live group and holds every permission, the tracker grants the drain engine the group's log range and asks for remote coherence traffic to be held off while the range drains.

A conflicting remote write to a line that a group read speculatively is reported as a violation against that group. The tracker then discards that group and every younger one. It reports which checkpoint to restore and which groups died, and it says whether surviving older groups must have their stores replayed. After a rollback no new group opens until some store has committed, so the core always makes forward progress.

Slots are reused as a ring of `NGRP` entries (a power of two). The store log index is tracked internally: it is 0 after reset and advances by one for every store appended to an accumulating group.

Top module: `spec_group_tracker`

## Requirements
- R1: After reset no group is live: `commit_grant`, `snoop_hold`, `ckpt_req`, `rb_valid` and `clr_valid` are 0.
- R2: An `open_req` with a free slot and no pending progress block allocates the next slot in ring order, starting at slot 0 after reset. It pulses `ckpt_req` for one cycle after that clock edge, with `ckpt_id` naming the slot. If a group was accumulating, that group closes at the same edge.
- R3: A store with `st_new_line`=1 raises the accumulating group's line count by one, and a store with `st_new_line`=0 leaves it unchanged. The store that brings the count to `LINE_LIMIT` (16) closes the group and opens the next one, with its `ckpt_req` pulse.
- R4: `commit_grant` rises only for the oldest live group, only after that group has closed, and only once its permission count equals its line count. A `perm_valid` pulse adds one permission to each live group whose bit is set in `perm_mask`.
- R5: A group that already holds all its permissions when it closes, and is then the oldest, shows `commit_grant` right after the closing edge without passing through a waiting cycle.
- R6: While granted, `commit_first` and `commit_end` give the group's log range as [first, end), and `commit_id` names its slot.
- R7: `commit_done` while granted retires the oldest group. It pulses `clr_valid` with `clr_id` for the bulk clear of that group's read and write markers, and the next-oldest group becomes the grant candidate.
- R8: `snoop_hold` is high exactly while a group is granted for commit.
- R9: A `viol_valid` against an accumulating or waiting group pulses `rb_valid` with `rb_id` set to that group. `rb_mask` has one bit set per discarded slot (the violating group and all younger ones). `rb_replay` is 1 when older groups survive and 0 when the violating group was the oldest. The log index returns to the violating group's first index.
- R10: After a rollback, `open_req` is ignored until a `commit_done` is seen.
- R11: With all `NGRP` slots live, `open_req` allocates nothing and `ckpt_req` stays 0.
- R12: A violation naming a free slot is ignored: `rb_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| open_req | input | 1 | Ordering rule would stall retirement: start a new group |
| st_valid | input | 1 | A retiring store is appended to the log |
| st_new_line | input | 1 | That store writes a line not yet written by its group |
| perm_valid | input | 1 | Write permission for a line arrived |
| perm_mask | input | NGRP | Groups that wrote the filled line |
| viol_valid | input | 1 | Conflicting remote write hit a speculatively read line |
| viol_id | input | log2(NGRP) | Group that read the line |
| commit_done | input | 1 | Drain of the granted group (or a plain store) finished |
| ckpt_req | output | 1 | Take a register checkpoint for a new group |
| ckpt_id | output | log2(NGRP) | Slot of the new group |
| rb_valid | output | 1 | Roll back |
| rb_id | output | log2(NGRP) | Checkpoint slot to restore |
| rb_mask | output | NGRP | Discarded slots |
| rb_replay | output | 1 | Older groups survive; replay their log entries |
| commit_grant | output | 1 | Oldest group may drain |
| commit_id | output | log2(NGRP) | Slot being drained |
| commit_first | output | LOG_W | First log index of the group |
| commit_end | output | LOG_W | One past the last log index of the group |
| snoop_hold | output | 1 | Hold off external coherence requests |
| clr_valid | output | 1 | Bulk-clear marker bits of a retired group |
| clr_id | output | log2(NGRP) | Slot to clear |

## Verification
The grant logic is exercised in several ways. A group is filled with a mix of repeated-line and new-line stores and closed with permissions still missing, which separates the line count from the store count. A group is given all of its permissions while it is still accumulating and then closed, which separates the direct path from the waiting one. Sixteen distinct lines are written, with a repeated line in between, so that the limit close is told apart from an off-by-one. Violations are aimed at a middle-aged group with all slots full, at the oldest group, and at a free slot, which separates cascade masks, the replay flag, the log rewind and the progress block.

// File: rtl/spec_group_tracker.sv
module spec_group_tracker #(
  parameter int NGRP       = 4,
  parameter int LINE_LIMIT = 16,
  parameter int LOG_W      = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     open_req,
  input  logic                     st_valid,
  input  logic                     st_new_line,
  input  logic                     perm_valid,
  input  logic [NGRP-1:0]          perm_mask,
  input  logic                     viol_valid,
  input  logic [$clog2(NGRP)-1:0]  viol_id,
  input  logic                     commit_done,
  output logic                     ckpt_req,
  output logic [$clog2(NGRP)-1:0]  ckpt_id,
  output logic                     rb_valid,
  output logic [$clog2(NGRP)-1:0]  rb_id,
  output logic [NGRP-1:0]          rb_mask,
  output logic                     rb_replay,
  output logic                     commit_grant,
  output logic [$clog2(NGRP)-1:0]  commit_id,
  output logic [LOG_W-1:0]         commit_first,
  output logic [LOG_W-1:0]         commit_end,
  output logic                     snoop_hold,
  output logic                     clr_valid,
  output logic [$clog2(NGRP)-1:0]  clr_id
);
  localparam int GW = $clog2(NGRP);
  localparam int CW = $clog2(NGRP + 1);
  localparam int LW = $clog2(LINE_LIMIT + 1);

  typedef enum logic [1:0] {G_FREE, G_ACC, G_WAIT, G_COMMIT} gst_t;

  gst_t             st_q    [NGRP];
  gst_t             st_d    [NGRP];
  logic [LOG_W-1:0] lo_q    [NGRP];
  logic [LOG_W-1:0] lo_d    [NGRP];
  logic [LOG_W-1:0] end_q   [NGRP];
  logic [LOG_W-1:0] end_d   [NGRP];
  logic [LW-1:0]    lines_q [NGRP];
  logic [LW-1:0]    lines_d [NGRP];
  logic [LW-1:0]    fill_q  [NGRP];
  logic [LW-1:0]    fill_d  [NGRP];
  logic [GW-1:0]    head_q, head_d, tail_q, tail_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [LOG_W-1:0] lp_q, lp_d;
  logic             prog_q, prog_d;

  logic             ckpt_d, rbv_d, rbr_d, clrv_d;
  logic [GW-1:0]    ckpt_id_d, rb_id_d, clr_id_d;
  logic [NGRP-1:0]  rb_mask_d;

  logic [GW-1:0] cur, viol_age;
  logic          acc, viol_ok, retire;

  assign cur          = tail_q - 1'b1;
  assign acc          = (cnt_q != '0) && (st_q[cur] == G_ACC);
  assign viol_age     = viol_id - head_q;
  assign viol_ok      = viol_valid && (st_q[viol_id] == G_ACC || st_q[viol_id] == G_WAIT);
  assign commit_grant = (cnt_q != '0) && (st_q[head_q] == G_COMMIT);
  assign retire       = commit_done && commit_grant;
  assign commit_id    = head_q;
  assign commit_first = lo_q[head_q];
  assign commit_end   = end_q[head_q];
  assign snoop_hold   = commit_grant;

  always_comb begin
    logic          hit_limit, start;
    logic [GW-1:0] age;
    st_d = st_q; lo_d = lo_q; end_d = end_q; lines_d = lines_q; fill_d = fill_q;
    head_d = head_q; tail_d = tail_q; cnt_d = cnt_q; lp_d = lp_q;
    prog_d = prog_q & ~commit_done;
    ckpt_d = 1'b0; ckpt_id_d = ckpt_id;
    rbv_d = 1'b0; rb_id_d = rb_id; rbr_d = rb_replay; rb_mask_d = '0;
    clrv_d = 1'b0; clr_id_d = clr_id;
    hit_limit = 1'b0; start = 1'b0; age = '0;

    for (int g = 0; g < NGRP; g++)
      if (perm_valid && perm_mask[g] && st_q[g] != G_FREE && fill_q[g] < lines_q[g])
        fill_d[g] = fill_q[g] + 1'b1;

    if (viol_ok) begin
      for (int g = 0; g < NGRP; g++) begin
        age = GW'(g) - head_q;
        if (st_q[g] != G_FREE && age >= viol_age) begin
          st_d[g]      = G_FREE;
          rb_mask_d[g] = 1'b1;
        end
      end
      tail_d  = viol_id;
      cnt_d   = CW'(viol_age);
      lp_d    = lo_q[viol_id];
      prog_d  = 1'b1;
      rbv_d   = 1'b1;
      rb_id_d = viol_id;
      rbr_d   = (viol_age != '0);
    end else begin
      if (st_valid && acc) begin
        lp_d       = lp_q + 1'b1;
        end_d[cur] = lp_q + 1'b1;
        if (st_new_line) begin
          lines_d[cur] = lines_q[cur] + 1'b1;
          hit_limit    = (lines_q[cur] == LW'(LINE_LIMIT - 1));
        end
      end
      start = open_req || hit_limit;
      if (acc && start) st_d[cur] = G_WAIT;
      if (start && cnt_q < CW'(NGRP) && !prog_q) begin
        st_d[tail_q]    = G_ACC;
        lo_d[tail_q]    = lp_d;
        end_d[tail_q]   = lp_d;
        lines_d[tail_q] = '0;
        fill_d[tail_q]  = '0;
        tail_d          = tail_q + 1'b1;
        cnt_d           = cnt_q + 1'b1;
        ckpt_d          = 1'b1;
        ckpt_id_d       = tail_q;
      end
    end

    if (retire) begin
      st_d[head_q] = G_FREE;
      head_d       = head_q + 1'b1;
      cnt_d        = cnt_d - 1'b1;
      clrv_d       = 1'b1;
      clr_id_d     = head_q;
    end

    if (cnt_d != '0 && st_d[head_d] == G_WAIT && fill_d[head_d] == lines_d[head_d])
      st_d[head_d] = G_COMMIT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < NGRP; g++) begin
        st_q[g] <= G_FREE; lo_q[g] <= '0; end_q[g] <= '0;
        lines_q[g] <= '0; fill_q[g] <= '0;
      end
      head_q <= '0; tail_q <= '0; cnt_q <= '0; lp_q <= '0; prog_q <= 1'b0;
      ckpt_req <= 1'b0; ckpt_id <= '0;
      rb_valid <= 1'b0; rb_id <= '0; rb_mask <= '0; rb_replay <= 1'b0;
      clr_valid <= 1'b0; clr_id <= '0;
    end else begin
      st_q <= st_d; lo_q <= lo_d; end_q <= end_d; lines_q <= lines_d; fill_q <= fill_d;
      head_q <= head_d; tail_q <= tail_d; cnt_q <= cnt_d; lp_q <= lp_d; prog_q <= prog_d;
      ckpt_req <= ckpt_d; ckpt_id <= ckpt_id_d;
      rb_valid <= rbv_d; rb_id <= rb_id_d; rb_mask <= rb_mask_d; rb_replay <= rbr_d;
      clr_valid <= clrv_d; clr_id <= clr_id_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n) begin
      for (int g = 0; g < NGRP; g++) begin
        a_r3_lines_cap: assert (lines_q[g] <= LW'(LINE_LIMIT));
        a_r4_fill_le_lines: assert (fill_q[g] <= lines_q[g]);
      end
    end
  end

  a_r4_grant_full: assert property (@(posedge clk) disable iff (!rst_n)
    commit_grant |-> fill_q[head_q] == lines_q[head_q]);
  a_r7_clear_after_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_done && commit_grant) |=> clr_valid);
  a_r9_rb_from_viol: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid |-> $past(viol_valid));
  a_r9_rb_no_open: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid |-> !ckpt_req);
  a_r10_open_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_req |-> !$past(prog_q));
  a_r11_cnt_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(NGRP));
endmodule

// File: tb/tb_spec_group_tracker.sv
`timescale 1ns/1ps
module tb_spec_group_tracker;
  logic clk = 1'b0, rst_n = 1'b0;
  logic open_req = 0, st_valid = 0, st_new_line = 0, perm_valid = 0, viol_valid = 0, commit_done = 0;
  logic [3:0] perm_mask = '0;
  logic [1:0] viol_id = '0;
  logic ckpt_req, rb_valid, rb_replay, commit_grant, snoop_hold, clr_valid;
  logic [1:0] ckpt_id, rb_id, commit_id, clr_id;
  logic [3:0] rb_mask;
  logic [9:0] commit_first, commit_end;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  spec_group_tracker dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    open_req = 0; st_valid = 0; st_new_line = 0; perm_valid = 0;
    perm_mask = '0; viol_valid = 0; commit_done = 0;
  endtask

  task automatic store(input logic nl);
    st_valid = 1; st_new_line = nl; cyc();
  endtask

  task automatic t_reset();
    chk("R1 grant", commit_grant, 0);
    chk("R1 hold", snoop_hold, 0);
    chk("R1 ckpt", ckpt_req, 0);
    chk("R1 rb", rb_valid, 0);
    chk("R1 clr", clr_valid, 0);
  endtask

  task automatic t_basic();
    open_req = 1; cyc();
    chk("R2 ckpt", ckpt_req, 1); chk("R2 id", ckpt_id, 0);
    store(1);
    chk("R2 pulse ends", ckpt_req, 0);
    store(0); store(1);
    open_req = 1; cyc();
    chk("R2 next ckpt", ckpt_req, 1); chk("R2 next id", ckpt_id, 1);
    chk("R4 not full", commit_grant, 0);
    perm_valid = 1; perm_mask = 4'b0001; cyc();
    chk("R3 repeat not counted", commit_grant, 0);
    perm_valid = 1; perm_mask = 4'b0001; cyc();
    chk("R4 grant", commit_grant, 1); chk("R6 id", commit_id, 0);
    chk("R6 first", commit_first, 0); chk("R6 end", commit_end, 3);
    chk("R8 hold", snoop_hold, 1);
    cyc();
    chk("R4 grant held", commit_grant, 1);
    commit_done = 1; cyc();
    chk("R7 grant drops", commit_grant, 0); chk("R7 clr", clr_valid, 1);
    chk("R7 clr id", clr_id, 0); chk("R8 hold drops", snoop_hold, 0);
  endtask

  task automatic t_direct();
    store(1);
    perm_valid = 1; perm_mask = 4'b0010; cyc();
    chk("R4 acc no grant", commit_grant, 0);
    open_req = 1; cyc();
    chk("R5 direct", commit_grant, 1); chk("R5 id", commit_id, 1);
    chk("R6 first", commit_first, 3); chk("R6 end", commit_end, 4);
    chk("R2 ckpt id2", ckpt_id, 2);
    commit_done = 1; cyc();
    chk("R7 clr id1", clr_id, 1);
  endtask

  task automatic t_limit();
    for (int i = 0; i < 15; i++) store(1);
    chk("R3 below limit", ckpt_req, 0);
    store(0);
    chk("R3 repeat no close", ckpt_req, 0);
    store(1);
    chk("R3 limit close", ckpt_req, 1); chk("R3 limit id", ckpt_id, 3);
    chk("R4 waiting", commit_grant, 0);
  endtask

  task automatic t_rollback();
    open_req = 1; cyc(); chk("R2 id0 wrap", ckpt_id, 0);
    open_req = 1; cyc(); chk("R2 id1", ckpt_id, 1);
    open_req = 1; cyc(); chk("R11 full", ckpt_req, 0);
    viol_valid = 1; viol_id = 3; cyc();
    chk("R9 rb", rb_valid, 1); chk("R9 rb id", rb_id, 3);
    chk("R9 mask", rb_mask, 4'b1011); chk("R9 replay", rb_replay, 1);
    open_req = 1; cyc(); chk("R10 blocked", ckpt_req, 0);
    viol_valid = 1; viol_id = 0; cyc(); chk("R12 free viol", rb_valid, 0);
    for (int i = 0; i < 15; i++) begin perm_valid = 1; perm_mask = 4'b0100; cyc(); end
    chk("R4 15 of 16", commit_grant, 0);
    perm_valid = 1; perm_mask = 4'b0100; cyc();
    chk("R4 16 of 16", commit_grant, 1); chk("R6 id2", commit_id, 2);
    chk("R6 first4", commit_first, 4); chk("R6 end21", commit_end, 21);
    commit_done = 1; cyc(); chk("R7 clr id2", clr_id, 2);
    open_req = 1; cyc(); chk("R10 unblocked", ckpt_req, 1); chk("R10 id3", ckpt_id, 3);
  endtask

  task automatic t_oldest();
    store(1);
    viol_valid = 1; viol_id = 3; cyc();
    chk("R9 oldest rb", rb_valid, 1); chk("R9 oldest replay", rb_replay, 0);
    chk("R9 oldest mask", rb_mask, 4'b1000);
    open_req = 1; cyc(); chk("R10 blocked again", ckpt_req, 0);
    commit_done = 1; cyc(); chk("R7 no grant no clr", clr_valid, 0);
    open_req = 1; cyc(); chk("R10 reopen", ckpt_req, 1); chk("R9 slot reuse", ckpt_id, 3);
    store(1);
    open_req = 1; cyc();
    perm_valid = 1; perm_mask = 4'b1000; cyc();
    chk("R9 rewind grant", commit_grant, 1);
    chk("R9 rewind first", commit_first, 21); chk("R9 rewind end", commit_end, 22);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset(); t_basic(); t_direct(); t_limit(); t_rollback(); t_oldest();
      end
      begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule